// File: doc/BRIEF.md
# Per-VP Block Execution Sequencer

This block takes execute directives, each naming a virtual processor (VP) and the start address of a cached instruction block, and holds them in a small queue. It takes one directive at a time and reads the block's instructions one per cycle from an instruction store. It runs every instruction of the block for that VP before it takes the next directive. A stop bit in each instruction word marks the last instruction of the block.

For each register instruction the block turns the three virtual register indices into physical register file addresses. Indices below the configured shared count are common to all VPs and pass through unchanged. Higher indices are private to each VP and are placed at `index + vp * private`. Private state therefore sits after the shared region, in one slice per VP. A thread-fetch instruction carries no register work. It is sent back to the command manager with its VP and target block address.

The shared and private register counts can be written only while no directive is running or queued. The block reports the largest VP count the 32-entry register file can hold under the current split.

Top module: `vp_block_seq`

## Requirements
- R1: The directive queue holds 4 entries and executes directives in arrival order. `dir_ready` is low exactly when the queue is full.
- R2: In the cycle after a directive leaves the queue, `ic_addr` equals its start address. `ic_addr` then rises by one each cycle, and each cycle presents one instruction for the directive's VP.
- R3: The instruction with bit 0 (stop) set is the last of its block. The cycle after it has no valid output, and then the next queued directive starts.
- R4: A virtual index v taken from bits [6:2] (rd), [11:7] (rs1) or [16:12] (rs2) with v below the shared count maps to physical address v.
- R5: A virtual index v at or above the shared count maps to v + vp * private.
- R6: An instruction with bit 1 set is a thread fetch. It raises `tf_valid` with the VP and the target from bits [24:17], and `ins_valid` stays low for it.
- R7: A configuration write takes effect only when no directive is executing or queued. Otherwise it is ignored.
- R8: `max_vp` equals (32 - shared) / private, and 0 when private is 0.
- R9: After reset the split is 0 shared and 1 private (`max_vp` = 32), no output is valid, and `dir_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register split write strobe |
| cfg_shared | input | 6 | Shared register count |
| cfg_private | input | 6 | Private registers per VP |
| max_vp | output | 6 | Largest VP count under the current split |
| dir_valid | input | 1 | Directive offered |
| dir_ready | output | 1 | Queue has room |
| dir_vp | input | 7 | Directive VP number |
| dir_addr | input | 8 | Directive block start address |
| ic_addr | output | 8 | Instruction store read address |
| ic_data | input | 25 | Instruction word at `ic_addr` |
| ins_valid | output | 1 | Register instruction valid |
| ins_vp | output | 7 | VP of the current instruction |
| rd_paddr | output | 5 | Physical destination address |
| rs1_paddr | output | 5 | Physical source 1 address |
| rs2_paddr | output | 5 | Physical source 2 address |
| tf_valid | output | 1 | Thread fetch to command manager |
| tf_vp | output | 7 | Thread fetch VP |
| tf_addr | output | 8 | Thread fetch target block |

## Verification
The bench fills the queue behind a 20-instruction block. If `dir_ready` does not drop, directives would be lost. It attempts a split change while work is pending, so a design that accepts it would remap registers partway through a run. It also drives one-instruction blocks back to back and thread fetches next to register instructions. These expose a missing bubble after a stop, or a thread fetch that also raises `ins_valid`. Randomly chosen splits, including all-shared and zero-private cases, test the shared/private boundary of the address map and the division behind `max_vp`.

// File: rtl/vp_block_seq.sv
module vp_block_seq #(
  parameter int NREG   = 32,
  parameter int VP_W   = 7,
  parameter int ADDR_W = 8,
  parameter int QDEPTH = 4,
  localparam int RI_W  = $clog2(NREG),
  localparam int CNT_W = $clog2(NREG + 1),
  localparam int IW    = 17 + ADDR_W,
  localparam int QP_W  = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_shared,
  input  logic [CNT_W-1:0]  cfg_private,
  output logic [CNT_W-1:0]  max_vp,
  input  logic              dir_valid,
  output logic              dir_ready,
  input  logic [VP_W-1:0]   dir_vp,
  input  logic [ADDR_W-1:0] dir_addr,
  output logic [ADDR_W-1:0] ic_addr,
  input  logic [IW-1:0]     ic_data,
  output logic              ins_valid,
  output logic [VP_W-1:0]   ins_vp,
  output logic [RI_W-1:0]   rd_paddr,
  output logic [RI_W-1:0]   rs1_paddr,
  output logic [RI_W-1:0]   rs2_paddr,
  output logic              tf_valid,
  output logic [VP_W-1:0]   tf_vp,
  output logic [ADDR_W-1:0] tf_addr
);
  localparam int MW = RI_W + VP_W + CNT_W + 1;

  logic [VP_W+ADDR_W-1:0] q [QDEPTH];
  logic [QP_W-1:0] wp, rp;
  logic [QP_W:0]   cnt;
  logic            busy;
  logic [ADDR_W-1:0] pc;
  logic [VP_W-1:0] cur_vp;
  logic [CNT_W-1:0] shared_q, priv_q;

  logic push, pop, blk_end, cfg_take;

  assign dir_ready = cnt != (QP_W+1)'(QDEPTH);
  assign push      = dir_valid && dir_ready;
  assign pop       = !busy && cnt != '0;
  assign blk_end   = busy && ic_data[0];
  assign cfg_take  = cfg_we && !busy && cnt == '0;

  function automatic logic [RI_W-1:0] phys(input logic [RI_W-1:0] v,
                                           input logic [VP_W-1:0] p,
                                           input logic [CNT_W-1:0] sh,
                                           input logic [CNT_W-1:0] pr);
    logic [MW-1:0] t;
    if (CNT_W'(v) < sh) t = MW'(v);
    else                t = MW'(v) + MW'(p) * MW'(pr);
    return t[RI_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        q[wp] <= {dir_vp, dir_addr};
        wp <= QP_W'(wp + 1'b1);
      end
      if (pop) rp <= QP_W'(rp + 1'b1);
      cnt <= cnt + (QP_W+1)'(push) - (QP_W+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pc     <= '0;
      cur_vp <= '0;
    end else if (pop) begin
      busy          <= 1'b1;
      {cur_vp, pc}  <= q[rp];
    end else if (busy) begin
      busy <= !ic_data[0];
      pc   <= ADDR_W'(pc + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shared_q <= '0;
      priv_q   <= CNT_W'(1);
    end else if (cfg_take) begin
      shared_q <= cfg_shared;
      priv_q   <= cfg_private;
    end
  end

  assign max_vp = (priv_q == '0) ? '0 : CNT_W'((CNT_W'(NREG) - shared_q) / priv_q);

  assign ic_addr   = pc;
  assign ins_valid = busy && !ic_data[1];
  assign tf_valid  = busy && ic_data[1];
  assign ins_vp    = cur_vp;
  assign tf_vp     = cur_vp;
  assign tf_addr   = ic_data[IW-1:17];
  assign rd_paddr  = phys(ic_data[6:2],   cur_vp, shared_q, priv_q);
  assign rs1_paddr = phys(ic_data[11:7],  cur_vp, shared_q, priv_q);
  assign rs2_paddr = phys(ic_data[16:12], cur_vp, shared_q, priv_q);
endmodule

// File: rtl/vp_block_seq_chk.sv
module vp_block_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int QC_W   = 3,
  parameter int QDEPTH = 4,
  parameter int RI_W   = 5,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              blk_end,
  input logic [QC_W-1:0]   cnt,
  input logic              dir_ready,
  input logic [ADDR_W-1:0] ic_addr,
  input logic [RI_W-1:0]   rs1_v,
  input logic [RI_W-1:0]   rs1_paddr,
  input logic [CNT_W-1:0]  shared_q,
  input logic [CNT_W-1:0]  max_vp,
  input logic              ins_valid,
  input logic              tf_valid
);
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= QC_W'(QDEPTH));
  p_full_stalls_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == QC_W'(QDEPTH) |-> !dir_ready);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !blk_end |=> busy && ic_addr == ADDR_W'($past(ic_addr) + 1'b1));
  p_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> !ins_valid && !tf_valid);
  p_shared_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && CNT_W'(rs1_v) < shared_q |-> rs1_paddr == rs1_v);
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ins_valid, tf_valid}));
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || cnt != '0) |=> $stable(max_vp));
endmodule

bind vp_block_seq vp_block_seq_chk #(
  .ADDR_W(ADDR_W), .QC_W(QP_W + 1), .QDEPTH(QDEPTH), .RI_W(RI_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .blk_end(blk_end), .cnt(cnt),
  .dir_ready(dir_ready), .ic_addr(ic_addr), .rs1_v(ic_data[11:7]),
  .rs1_paddr(rs1_paddr), .shared_q(shared_q), .max_vp(max_vp),
  .ins_valid(ins_valid), .tf_valid(tf_valid)
);

// File: tb/tb_vp_block_seq.sv
module tb_vp_block_seq;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [5:0] cfg_shared = 0, cfg_private = 0, max_vp;
  logic dir_valid = 0, dir_ready;
  logic [6:0] dir_vp = 0;
  logic [7:0] dir_addr = 0, ic_addr, tf_addr;
  logic [24:0] ic_data;
  logic ins_valid, tf_valid;
  logic [6:0] ins_vp, tf_vp;
  logic [4:0] rd_paddr, rs1_paddr, rs2_paddr;

  logic [24:0] imem [256];
  assign ic_data = imem[ic_addr];

  vp_block_seq dut (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int m_sh = 0, m_pr = 1;
  logic [6:0] e_vp [1024];
  logic [7:0] e_addr [1024];
  int push_idx = 0, pop_idx = 0;
  logic m_busy = 0, last_stop = 0;
  logic [7:0] m_pc = 0;
  logic [6:0] m_vp = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int emap(input int v, input int vp);
    return (v < m_sh) ? v : (v + vp * m_pr) % 32;
  endfunction

  function automatic int emax(input int sh, input int pr);
    return (pr == 0) ? 0 : (32 - sh) / pr;
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (last_stop) chk(!ins_valid && !tf_valid, "R3 bubble", int'(ins_valid | tf_valid), 0);
    last_stop = 0;
    if (!m_busy && !last_stop && (ins_valid || tf_valid)) begin
      if (pop_idx == push_idx) chk(0, "R1 unexpected start", 1, 0);
      else begin
        m_pc = e_addr[pop_idx]; m_vp = e_vp[pop_idx];
        pop_idx++; m_busy = 1;
      end
    end
    if (m_busy) begin
      logic [24:0] w;
      w = imem[m_pc];
      chk(ic_addr == m_pc, "R2 ic_addr", int'(ic_addr), int'(m_pc));
      if (w[1]) begin
        chk(tf_valid && !ins_valid, "R6 tf strobe", int'({tf_valid, ins_valid}), 2);
        chk(tf_vp == m_vp && tf_addr == w[24:17], "R6 tf addr", int'(tf_addr), int'(w[24:17]));
      end else begin
        chk(ins_valid && !tf_valid, "R2 ins strobe", int'({ins_valid, tf_valid}), 2);
        chk(ins_vp == m_vp, "R2 vp", int'(ins_vp), int'(m_vp));
        chk(rd_paddr == 5'(emap(w[6:2], m_vp)), int'(w[6:2]) < m_sh ? "R4 rd" : "R5 rd",
            int'(rd_paddr), emap(w[6:2], m_vp));
        chk(rs1_paddr == 5'(emap(w[11:7], m_vp)), int'(w[11:7]) < m_sh ? "R4 rs1" : "R5 rs1",
            int'(rs1_paddr), emap(w[11:7], m_vp));
        chk(rs2_paddr == 5'(emap(w[16:12], m_vp)), int'(w[16:12]) < m_sh ? "R4 rs2" : "R5 rs2",
            int'(rs2_paddr), emap(w[16:12], m_vp));
      end
      if (w[0]) begin m_busy = 0; last_stop = 1; end
      else m_pc = m_pc + 1;
    end
  end

  task automatic cfg(input int sh, input int pr);
    @(negedge clk);
    cfg_we = 1; cfg_shared = 6'(sh); cfg_private = 6'(pr);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic push(input int vp, input int addr);
    @(negedge clk);
    while (!dir_ready) @(negedge clk);
    dir_valid = 1; dir_vp = 7'(vp); dir_addr = 8'(addr);
    e_vp[push_idx] = 7'(vp); e_addr[push_idx] = 8'(addr); push_idx++;
    @(posedge clk); #1;
    dir_valid = 0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    while (pop_idx != push_idx || m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic gen_prog();
    for (int b = 0; b < 8; b++) begin
      int len;
      len = 1 + $urandom % 8;
      for (int i = 0; i < len; i++) begin
        int rng;
        rng = m_sh + m_pr;
        imem[b*32+i] = {8'($urandom), 5'($urandom % rng), 5'($urandom % rng),
                        5'($urandom % rng), ($urandom % 4) == 0, i == len - 1};
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) imem[i] = 25'h1;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(max_vp == 32, "R9 max_vp", int'(max_vp), 32);
    chk(dir_ready && !ins_valid && !tf_valid, "R9 idle", int'({dir_ready, ins_valid, tf_valid}), 4);

    cfg(4, 4); m_sh = 4; m_pr = 4;
    @(negedge clk);
    chk(max_vp == 7, "R8 max_vp 4/4", int'(max_vp), 7);
    gen_prog();
    for (int i = 0; i < 20; i++)
      imem[224+i] = {8'd0, 5'(i % 8), 5'((i + 3) % 8), 5'((i + 5) % 8), 1'b0, i == 19};
    push(3, 224);
    for (int i = 0; i < 4; i++) push(i, i * 32);
    @(negedge clk);
    chk(!dir_ready, "R1 full", int'(dir_ready), 0);
    cfg(10, 2);
    @(negedge clk);
    chk(max_vp == 7, "R7 cfg ignored", int'(max_vp), 7);
    drain();
    chk(pop_idx == push_idx, "R1 all executed", pop_idx, push_idx);

    push(6, 0); push(5, 32); push(2, 64);
    drain();

    cfg(10, 2); m_sh = 10; m_pr = 2;
    @(negedge clk);
    chk(max_vp == 11, "R8 max_vp 10/2", int'(max_vp), 11);
    cfg(8, 0);
    @(negedge clk);
    chk(max_vp == 0, "R8 zero private", int'(max_vp), 0);
    cfg(31, 1);
    @(negedge clk);
    chk(max_vp == 1, "R8 31/1", int'(max_vp), 1);
    cfg(0, 32);
    @(negedge clk);
    chk(max_vp == 1, "R8 0/32", int'(max_vp), 1);
    cfg(32, 0);
    @(negedge clk);
    chk(max_vp == 0, "R8 all shared", int'(max_vp), 0);

    for (int r = 0; r < 8; r++) begin
      int sh, pr, mx;
      sh = $urandom % 25; pr = 1 + $urandom % 8; mx = emax(sh, pr);
      cfg(sh, pr); m_sh = sh; m_pr = pr;
      @(negedge clk);
      chk(int'(max_vp) == mx, "R8 random split", int'(max_vp), mx);
      gen_prog();
      for (int k = 0; k < 20; k++) push($urandom % mx, ($urandom % 8) * 32);
      drain();
      chk(pop_idx == push_idx, "R2 blocks done", pop_idx, push_idx);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule